// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit

This unit takes an IEEE 754 binary operand and returns the integral value in the same format that the selected rounding direction picks. One two-bit size code chooses 16-bit, 32-bit or 64-bit operation. A two-bit mode field, taken from a control register, sets the direction. A separate override input forces truncation whatever the field holds. The result always has the width of the operand. The unit never turns the value into an integer type.

Each accepted operand appears at the outputs one clock after `in_valid`, together with an invalid-operation flag and an illegal-size indication. The inexact flag exists for interface completeness and stays low. Narrow operands travel in the low bits of a 64-bit lane. All bits above the format width are ignored on the way in and cleared on the way out.

Top module: `fp_rint`

## Requirements
- R1: `size` 2'b01 selects 16-bit, 2'b10 selects 32-bit and 2'b11 selects 64-bit operation. The outputs for an operand accepted with `in_valid` at one rising edge are valid, with `out_valid` high, after that same edge.
- R2: `rmode` 2'b00 rounds to nearest, 2'b01 toward +infinity, 2'b10 toward -infinity and 2'b11 toward zero. When `force_rz` is 1 the unit rounds toward zero whatever `rmode` holds.
- R3: A zero operand returns the same zero. The sign bit of every result equals the operand's sign bit.
- R4: An infinite operand returns the same infinity.
- R5: A signaling NaN (exponent all ones, fraction nonzero, top fraction bit 0) returns with its top fraction bit set and raises `flag_invalid`. A quiet NaN (top fraction bit 1) returns unchanged with `flag_invalid` low.
- R6: `flag_inexact` is 0 for every operand, including ones whose fraction bits are discarded.
- R7: `size` 2'b00 sets `undef` to 1, with `result` zero and `flag_invalid` low.
- R8: A 16-bit operand is read from `operand[15:0]` and a 32-bit operand from `operand[31:0]`. Higher operand bits have no effect, and result bits above the format width are 0.
- R9: An operand whose unbiased exponent is at least the fraction width passes through unchanged.
- R10: A nonzero operand of magnitude below 1 rounds to a zero or to 1.0 with the operand's sign. For example, -0.3 toward +infinity gives -0.0.
- R11: When rounding up carries out of the fraction, the exponent increments and the result is a well-formed value (255.5 rounds to 256.0).
- R12: Round to nearest breaks exact ties toward the even integer: 0.5 gives 0, 1.5 gives 2 and 2.5 gives 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand and controls are presented this cycle |
| size | input | 2 | Format select: 01 half, 10 single, 11 double, 00 illegal |
| rmode | input | 2 | Rounding-direction field from the control register |
| force_rz | input | 1 | Forces rounding toward zero |
| operand | input | 64 | Operand, right-aligned in the lane |
| out_valid | output | 1 | Outputs hold a new result |
| result | output | 64 | Rounded value, zero-extended above the format width |
| flag_invalid | output | 1 | Signaling NaN was quieted |
| flag_inexact | output | 1 | Inexact indication, always 0 |
| undef | output | 1 | Illegal size code was presented |

## Verification
The hardest cases to reach are operands that lie exactly halfway between two integers, and round-ups that carry from an all-ones fraction into the exponent. Uniform random bit patterns almost never produce either. The stimulus therefore draws most exponents from a window around the integral threshold. It often clears a random number of low fraction bits, which creates exact halves and exact integers, and it adds directed operands such as 0.5, 2.5 and 255.5. Expected values come from real-number floor and ceiling in the bench, which checks the bit-level rounding by a different route.

// File: rtl/fp_rint_pkg.sv
package fp_rint_pkg;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_POS_INF   = 2'b01,
    RND_NEG_INF   = 2'b10,
    RND_ZERO      = 2'b11
  } rnd_dir_e;

  localparam int LANE_W    = 64;
  localparam int NUM_FMT   = 3;
  localparam logic [1:0] SZ_ILLEGAL = 2'b00;
  localparam logic [1:0] SZ_HALF    = 2'b01;
  localparam logic [1:0] SZ_SINGLE  = 2'b10;
  localparam logic [1:0] SZ_DOUBLE  = 2'b11;

  function automatic int fmt_exp_w(input int idx);
    return (idx == 0) ? 5 : (idx == 1) ? 8 : 11;
  endfunction

  function automatic int fmt_frac_w(input int idx);
    return (idx == 0) ? 10 : (idx == 1) ? 23 : 52;
  endfunction

endpackage

// File: rtl/fp_rint_rstsync.sv
module fp_rint_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/fp_rint_mode.sv
module fp_rint_mode
  import fp_rint_pkg::*;
(
  input  logic [1:0] rmode,
  input  logic       force_rz,
  output rnd_dir_e   dir
);
  always_comb begin
    if (force_rz) dir = RND_ZERO;
    else          dir = rnd_dir_e'(rmode);
  end
endmodule

// File: rtl/fp_rint_lane.sv
module fp_rint_lane
  import fp_rint_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] operand,
  input  rnd_dir_e              dir,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  invalid
);
  localparam int W       = EXP_W + FRAC_W + 1;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int INT_LIM = BIAS + FRAC_W;
  localparam logic [EXP_W-1:0] ONE_EXP = EXP_W'(BIAS);

  logic              sgn;
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic [W-2:0]      mag;
  logic [W-2:0]      unit, half, fmask, fpart, trunc;
  logic              lsb, up;
  int                nf;

  always_comb begin
    sgn     = operand[W-1];
    expo    = operand[W-2:FRAC_W];
    frac    = operand[FRAC_W-1:0];
    mag     = operand[W-2:0];
    result  = operand;
    invalid = 1'b0;
    nf      = 0;
    unit    = '0;
    half    = '0;
    fmask   = '0;
    fpart   = '0;
    trunc   = '0;
    lsb     = 1'b0;
    up      = 1'b0;
    if (&expo) begin
      if (|frac) begin
        result[FRAC_W-1] = 1'b1;
        invalid          = ~frac[FRAC_W-1];
      end
    end else if (int'(expo) >= INT_LIM) begin
      result = operand;
    end else if (expo == '0 && frac == '0) begin
      result = operand;
    end else if (int'(expo) < BIAS) begin
      unique case (dir)
        RND_NEAR_EVEN: up = (int'(expo) == BIAS - 1) && (frac != '0);
        RND_POS_INF:   up = ~sgn;
        RND_NEG_INF:   up = sgn;
        default:       up = 1'b0;
      endcase
      result = {sgn, (up ? ONE_EXP : {EXP_W{1'b0}}), {FRAC_W{1'b0}}};
    end else begin
      nf    = INT_LIM - int'(expo);
      unit  = (W-1)'(1) << nf;
      half  = unit >> 1;
      fmask = unit - (W-1)'(1);
      fpart = mag & fmask;
      trunc = mag & ~fmask;
      lsb   = (nf == FRAC_W) ? 1'b1 : |(mag & unit);
      unique case (dir)
        RND_NEAR_EVEN: up = (fpart > half) || ((fpart == half) && lsb);
        RND_POS_INF:   up = (fpart != '0) && ~sgn;
        RND_NEG_INF:   up = (fpart != '0) && sgn;
        default:       up = 1'b0;
      endcase
      result = {sgn, trunc + (up ? unit : '0)};
    end
  end
endmodule

// File: rtl/fp_rint.sv
module fp_rint
  import fp_rint_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  size,
  input  logic [1:0]  rmode,
  input  logic        force_rz,
  input  logic [63:0] operand,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        flag_invalid,
  output logic        flag_inexact,
  output logic        undef
);
  logic     rst_n_sync;
  rnd_dir_e dir;

  logic [LANE_W-1:0] lane_res [NUM_FMT];
  logic              lane_inv [NUM_FMT];

  logic [LANE_W-1:0] nxt_result, result_q;
  logic              nxt_inv, inv_q;
  logic              nxt_undef, undef_q;
  logic              valid_q;
  logic              load_en;

  fp_rint_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  fp_rint_mode u_mode (
    .rmode    (rmode),
    .force_rz (force_rz),
    .dir      (dir)
  );

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int EW = fmt_exp_w(g);
    localparam int FW = fmt_frac_w(g);
    logic [EW+FW:0] l_out;
    logic           l_inv;

    fp_rint_lane #(.EXP_W(EW), .FRAC_W(FW)) u_lane (
      .operand (operand[EW+FW:0]),
      .dir     (dir),
      .result  (l_out),
      .invalid (l_inv)
    );

    assign lane_res[g] = LANE_W'(l_out);
    assign lane_inv[g] = l_inv;
  end

  always_comb begin
    nxt_result = '0;
    nxt_inv    = 1'b0;
    nxt_undef  = 1'b0;
    unique case (size)
      SZ_HALF:   begin nxt_result = lane_res[0]; nxt_inv = lane_inv[0]; end
      SZ_SINGLE: begin nxt_result = lane_res[1]; nxt_inv = lane_inv[1]; end
      SZ_DOUBLE: begin nxt_result = lane_res[2]; nxt_inv = lane_inv[2]; end
      default:   nxt_undef = 1'b1;
    endcase
  end

  assign load_en = in_valid;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      inv_q    <= 1'b0;
      undef_q  <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (load_en) begin
        result_q <= nxt_result;
        inv_q    <= nxt_inv;
        undef_q  <= nxt_undef;
      end
    end
  end

  assign out_valid    = valid_q;
  assign result       = result_q;
  assign flag_invalid = inv_q;
  assign flag_inexact = 1'b0;
  assign undef        = undef_q;

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    in_valid |=> out_valid);

  assert_illegal_size_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && size == SZ_ILLEGAL) |=> (undef && result == '0 && !flag_invalid));

  assert_half_upper_R8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && size == SZ_HALF) |=> (result[63:16] == '0));

  assert_single_sign_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && size == SZ_SINGLE) |=> (result[31] == $past(operand[31]) && result[63:32] == '0));

  assert_double_inf_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && size == SZ_DOUBLE && operand[62:52] == '1 && operand[51:0] == '0)
      |=> (result == $past(operand)));

  assert_quiet_nan_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && size == SZ_SINGLE && operand[30:22] == '1)
      |=> (result[31:0] == $past(operand[31:0]) && !flag_invalid));
endmodule

// File: tb/fp_rint_tb.sv
module fp_rint_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  size;
  logic [1:0]  rmode;
  logic        force_rz;
  logic [63:0] operand;
  logic        out_valid;
  logic [63:0] result;
  logic        flag_invalid;
  logic        flag_inexact;
  logic        undef;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  fp_rint u_dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .size (size),
    .rmode (rmode), .force_rz (force_rz), .operand (operand),
    .out_valid (out_valid), .result (result), .flag_invalid (flag_invalid),
    .flag_inexact (flag_inexact), .undef (undef)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int ew_of(input logic [1:0] sz);
    return (sz == 2'b01) ? 5 : (sz == 2'b10) ? 8 : 11;
  endfunction

  function automatic int fw_of(input logic [1:0] sz);
    return (sz == 2'b01) ? 10 : (sz == 2'b10) ? 23 : 52;
  endfunction

  function automatic real to_real(input logic [63:0] bits, input int ew, input int fw);
    int          bias = (1 << (ew - 1)) - 1;
    int          ex   = int'((bits >> fw) & ((64'd1 << ew) - 1));
    logic [63:0] fr   = bits & ((64'd1 << fw) - 1);
    if (ex == 0) return real'(fr) * (2.0 ** (1 - bias - fw));
    return real'(fr + (64'd1 << fw)) * (2.0 ** (ex - bias - fw));
  endfunction

  function automatic logic [63:0] from_real(input real r, input int ew, input int fw);
    int          bias = (1 << (ew - 1)) - 1;
    int          e = 0;
    logic [63:0] fr;
    while (2.0 ** (e + 1) <= r) e++;
    fr = 64'(longint'((r / (2.0 ** e) - 1.0) * (2.0 ** fw)));
    return (64'(e + bias) << fw) | fr;
  endfunction

  function automatic void ref_model(input logic [1:0] sz, input logic [1:0] md,
                                    input logic fz, input logic [63:0] op,
                                    output logic [63:0] res, output logic inv,
                                    output logic und);
    int          ew, fw;
    logic [63:0] w, fr;
    logic        sg;
    int          ex;
    real         v, f, r;
    logic [1:0]  eff;
    res = '0; inv = 1'b0; und = 1'b0;
    if (sz == 2'b00) begin und = 1'b1; return; end
    ew  = ew_of(sz);
    fw  = fw_of(sz);
    w   = (ew + fw == 63) ? op : (op & ((64'd1 << (ew + fw + 1)) - 1));
    sg  = w[ew + fw];
    ex  = int'((w >> fw) & ((64'd1 << ew) - 1));
    fr  = w & ((64'd1 << fw) - 1);
    eff = fz ? 2'b11 : md;
    if (ex == (1 << ew) - 1) begin
      if (fr == 0) res = w;
      else begin
        res = w | (64'd1 << (fw - 1));
        inv = ~fr[fw - 1];
      end
      return;
    end
    v = to_real(w, ew, fw);
    if (sg) v = -v;
    f = $floor(v);
    case (eff)
      2'b00: begin
        if (v - f > 0.5)      r = f + 1.0;
        else if (v - f < 0.5) r = f;
        else                  r = ($floor(f / 2.0) * 2.0 == f) ? f : f + 1.0;
      end
      2'b01:   r = $ceil(v);
      2'b10:   r = f;
      default: r = (v < 0.0) ? $ceil(v) : f;
    endcase
    if (r < 0.0) r = -r;
    if (r == 0.0) res = 64'(sg) << (ew + fw);
    else          res = from_real(r, ew, fw) | (64'(sg) << (ew + fw));
  endfunction

  task automatic check(input string tag, input logic [63:0] exp_res,
                       input logic exp_inv, input logic exp_und);
    checks++;
    if (!out_valid || result !== exp_res || flag_invalid !== exp_inv ||
        undef !== exp_und || flag_inexact !== 1'b0) begin
      errors++;
      $display("FAIL %s: got v=%0b res=%h inv=%0b und=%0b inx=%0b, expected v=1 res=%h inv=%0b und=%0b inx=0",
               tag, out_valid, result, flag_invalid, undef, flag_inexact,
               exp_res, exp_inv, exp_und);
    end
  endtask

  task automatic apply(input logic [1:0] sz, input logic [1:0] md, input logic fz,
                       input logic [63:0] op);
    @(negedge clk);
    in_valid = 1'b1; size = sz; rmode = md; force_rz = fz; operand = op;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic directed(input string tag, input logic [1:0] sz, input logic [1:0] md,
                          input logic fz, input logic [63:0] op,
                          input logic [63:0] exp_res, input logic exp_inv,
                          input logic exp_und);
    apply(sz, md, fz, op);
    check(tag, exp_res, exp_inv, exp_und);
  endtask

  task automatic via_ref(input string tag, input logic [1:0] sz, input logic [1:0] md,
                         input logic fz, input logic [63:0] op);
    logic [63:0] er;
    logic        ei, eu;
    ref_model(sz, md, fz, op, er, ei, eu);
    apply(sz, md, fz, op);
    check(tag, er, ei, eu);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    in_valid = 1'b0; size = 2'b10; rmode = 2'b00; force_rz = 1'b0; operand = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    checks++;
    if (out_valid !== 1'b0 || result !== 64'd0 || flag_invalid !== 1'b0 || undef !== 1'b0) begin
      errors++;
      $display("FAIL reset R1: got v=%0b res=%h, expected v=0 res=0", out_valid, result);
    end

    directed("R11 R12 1.5 nearest",   2'b10, 2'b00, 1'b0, 64'h3FC00000, 64'h40000000, 0, 0);
    directed("R12 2.5 nearest",       2'b10, 2'b00, 1'b0, 64'h40200000, 64'h40000000, 0, 0);
    directed("R12 0.5 nearest",       2'b10, 2'b00, 1'b0, 64'h3F000000, 64'h00000000, 0, 0);
    directed("R10 -0.3 toward +inf",  2'b10, 2'b01, 1'b0, 64'hBE99999A, 64'h80000000, 0, 0);
    directed("R10 -0.3 toward -inf",  2'b10, 2'b10, 1'b0, 64'hBE99999A, 64'hBF800000, 0, 0);
    directed("R2 override truncates", 2'b10, 2'b01, 1'b1, 64'h402CCCCD, 64'h40000000, 0, 0);
    directed("R2 +inf mode 2.7",      2'b10, 2'b01, 1'b0, 64'h402CCCCD, 64'h40400000, 0, 0);
    directed("R11 255.5 carry",       2'b10, 2'b00, 1'b0, 64'h437F8000, 64'h43800000, 0, 0);
    directed("R8 R1 half lane",       2'b01, 2'b11, 1'b0, 64'hFFFF_FFFF_DEAD_3E00, 64'h3C00, 0, 0);
    directed("R8 single lane",        2'b10, 2'b11, 1'b0, 64'h1234_5678_3FC0_0000, 64'h3F800000, 0, 0);
    directed("R5 double sNaN",        2'b11, 2'b00, 1'b0, 64'h7FF0000000000001, 64'h7FF8000000000001, 1, 0);
    directed("R5 single qNaN",        2'b10, 2'b00, 1'b0, 64'h7FC00001, 64'h7FC00001, 0, 0);
    directed("R4 single -inf",        2'b10, 2'b01, 1'b0, 64'hFF800000, 64'hFF800000, 0, 0);
    directed("R3 double -0",          2'b11, 2'b01, 1'b0, 64'h8000000000000000, 64'h8000000000000000, 0, 0);
    directed("R9 large single",       2'b10, 2'b01, 1'b0, 64'h4B000001, 64'h4B000001, 0, 0);
    directed("R7 illegal size",       2'b00, 2'b00, 1'b0, 64'h3FC00000, 64'h0, 0, 1);
    directed("R6 R1 double 2.5 -inf", 2'b11, 2'b10, 1'b0, 64'h4004000000000000, 64'h4000000000000000, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      logic [1:0]  sz = 2'($urandom % 16 == 0 ? 0 : 1 + $urandom % 3);
      int          ew = ew_of(sz);
      int          fw = fw_of(sz);
      int          bias = (1 << (ew - 1)) - 1;
      logic [63:0] fr = {$urandom, $urandom} & ((64'd1 << fw) - 1);
      logic [63:0] ex = {$urandom, $urandom} & ((64'd1 << ew) - 1);
      logic [63:0] op;
      int          pick = int'($urandom % 8);
      if (pick == 1)      ex = (64'd1 << ew) - 1;
      else if (pick == 2) ex = 0;
      else if (pick > 2)  ex = 64'(bias - 2 + int'($urandom % (fw + 4)));
      if ($urandom % 3 == 0) fr = fr & ~((64'd1 << ($urandom % (fw + 1))) - 1);
      op = (ex << fw) | fr | (64'($urandom % 2) << (ew + fw));
      if (ew + fw < 63) op = op | ({$urandom, $urandom} & ~((64'd1 << (ew + fw + 1)) - 1));
      via_ref("R2 R8 R9 R10 R11 R12 random", sz, 2'($urandom), 1'($urandom % 8 == 0), op);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule